// File: doc/BRIEF.md
# Posted-write timer register bank

This block holds the software-visible registers of a timer, which are written on a fast host clock and used on a slower timer clock. A host write to one of the three timer-side registers (reload value, match value, timer control) goes into a per-register crossing slot. The slot hands the value to the timer domain with a toggle request/acknowledge handshake, and the data stays stable on the host side until the timer domain acknowledges it. When posting is switched on, the host port takes the write at once and the transfer completes in the background. A status register shows, bit by bit, which registers still have a transfer in flight. When posting is off, the host port drops its ready signal after the write until the timer domain has taken the value.

Registers can be written whole or as two 16-bit halves, low half first. For the reload register, a low half on its own already counts as an update. For the match and control registers, the update happens only when the high half arrives. If a register is written again while a transfer is still in flight, the newest value waits in a single queue entry and replaces any value queued before it. A free-running count of timer-clock cycles is kept in the host domain, so a read returns it without any synchronizer delay.

Top module: `posted_reg_bank`

## Requirements
- R1: After reset, `host_ready` is 1, the three timer-side outputs are 0, the status register reads 0 and posting is off.
- R2: Address 0 is the interface control register. Bit 2 enables posting. A full write (`host_size`=00) or a low-half write (01) sets this bit, a high-half write (10) leaves it unchanged, and a read returns the bit in position 2 with all other bits 0.
- R3: With posting on, a write to any register is accepted in the cycle it is presented: `host_ready` is 1 while `host_valid` is 1.
- R4: Address 1 is the status register: bit 0 = reload (address 2), bit 1 = match (address 3), bit 2 = control (address 4). A bit reads 1 from the cycle after an update is accepted until the timer domain has applied the value. After the bit clears, the matching timer-side output carries the written value.
- R5: Several updates to one register while it is still pending leave only the newest value in the timer domain. A value that was replaced while it waited in the queue never appears on the timer-side output.
- R6: A read of a register whose update is still pending returns the value applied before that update.
- R7: For a half-word write, the data is taken from `host_wdata[15:0]`. For the reload register, a low-half write on its own is an update, giving {previous high half, new low half}.
- R8: For the match and control registers, a low-half write only stages the data and sets no status bit. The following high-half write applies {high, staged low}.
- R9: With posting off, after a write that makes an update is accepted, `host_ready` is 0 from the next cycle until that register's status bit has cleared. By then the timer-side output holds the value.
- R10: Address 5 returns a count of timer-clock cycles, kept in the host domain. It rises by at most 1 per host cycle and tracks the timer clock to within a couple of cycles.
- R11: A read accepted on a host clock edge produces `host_rvalid` = 1 with the read data in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host interface clock |
| host_rst | input | 1 | Synchronous active-high reset, host domain |
| tmr_clk | input | 1 | Timer clock, below a quarter of host_clk |
| tmr_rst | input | 1 | Synchronous active-high reset, timer domain |
| host_valid | input | 1 | Access request |
| host_ready | output | 1 | Request is accepted when valid and ready are both 1 |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW | Register index (0 control, 1 status, 2 reload, 3 match, 4 timer control, 5 counter) |
| host_size | input | 2 | 00 full word, 01 low half, 10 high half |
| host_wdata | input | DW | Write data; half writes use bits 15:0 |
| host_rvalid | output | 1 | Read data valid, one cycle after read accept |
| host_rdata | output | DW | Read data |
| tmr_load | output | DW | Reload value applied in the timer domain |
| tmr_cmp | output | DW | Match value applied in the timer domain |
| tmr_ctrl | output | DW | Control value applied in the timer domain |

## Verification
The assertions rely on two things: the timer clock runs at less than a quarter of the host clock, and the posting bit cannot change while a non-posted stall is in progress. The second holds because `host_ready` is low for the whole stall. The bench drives a 40 ns timer clock against the 8 ns host clock. It changes requests only between clock edges and holds a request until `host_ready` is seen high, so every write takes effect in a known cycle. For the replacement case, the writes are spaced closer together than the shortest possible crossing, so the first value is certain to still be in flight when the later ones arrive.

// File: rtl/prb_pkg.sv
package prb_pkg;
  typedef enum logic [1:0] {
    SZ_FULL = 2'b00,
    SZ_LO   = 2'b01,
    SZ_HI   = 2'b10,
    SZ_NONE = 2'b11
  } acc_e;

  localparam int unsigned NSLOT    = 3;
  localparam int unsigned A_IFCTRL = 0;
  localparam int unsigned A_STAT   = 1;
  localparam int unsigned A_LOAD   = 2;
  localparam int unsigned A_COUNT  = A_LOAD + NSLOT;

  function automatic logic makes_update(acc_e kind, logic low_commits);
    return (kind == SZ_FULL) || (kind == SZ_HI) || (low_commits && kind == SZ_LO);
  endfunction
endpackage

// File: rtl/prb_slot.sv
module prb_slot import prb_pkg::*; #(
  parameter int unsigned DW     = 32,
  parameter bit          IS_CNT = 1'b0
) (
  input  logic          host_clk,
  input  logic          host_rst,
  input  logic          tmr_clk,
  input  logic          tmr_rst,
  input  logic          wr_en,
  input  acc_e          wr_kind,
  input  logic [DW-1:0] wr_data,
  output logic          commit,
  output logic          pending,
  output logic [DW-1:0] mirror,
  output logic [DW-1:0] tmr_val
);
  localparam int unsigned HW = DW / 2;

  logic [DW-1:0] data_q, next_q, latest_q, mirror_q, new_val;
  logic [HW-1:0] stage_q;
  logic          req_q, queued_q, ack_s1, ack_s2, busy_w;
  logic          req_s1, req_s2, seen_q;
  logic [DW-1:0] val_q;

  assign commit = wr_en && makes_update(wr_kind, IS_CNT);
  assign busy_w = req_q ^ ack_s2;

  always_comb begin
    new_val = latest_q;
    case (wr_kind)
      SZ_FULL: new_val = wr_data;
      SZ_LO:   new_val = {latest_q[DW-1:HW], wr_data[HW-1:0]};
      SZ_HI:   new_val = IS_CNT ? {wr_data[HW-1:0], latest_q[HW-1:0]}
                                : {wr_data[HW-1:0], stage_q};
      default: new_val = latest_q;
    endcase
  end

  always_ff @(posedge host_clk) begin
    if (host_rst) begin
      data_q   <= '0;
      next_q   <= '0;
      latest_q <= '0;
      mirror_q <= '0;
      stage_q  <= '0;
      req_q    <= 1'b0;
      queued_q <= 1'b0;
      ack_s1   <= 1'b0;
      ack_s2   <= 1'b0;
    end else begin
      ack_s1 <= seen_q;
      ack_s2 <= ack_s1;
      if (wr_en && wr_kind == SZ_LO) stage_q <= wr_data[HW-1:0];
      if (commit) begin
        latest_q <= new_val;
        if (!busy_w) begin
          data_q   <= new_val;
          req_q    <= ~req_q;
          queued_q <= 1'b0;
        end else begin
          next_q   <= new_val;
          queued_q <= 1'b1;
        end
      end else if (!busy_w && queued_q) begin
        data_q   <= next_q;
        req_q    <= ~req_q;
        queued_q <= 1'b0;
      end
      if (!busy_w && !queued_q) mirror_q <= data_q;
    end
  end

  always_ff @(posedge tmr_clk) begin
    if (tmr_rst) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      seen_q <= 1'b0;
      val_q  <= '0;
    end else begin
      req_s1 <= req_q;
      req_s2 <= req_s1;
      if (req_s2 != seen_q) begin
        val_q  <= data_q;
        seen_q <= req_s2;
      end
    end
  end

  assign pending = busy_w | queued_q;
  assign mirror  = mirror_q;
  assign tmr_val = val_q;
endmodule

// File: rtl/prb_tick_count.sv
module prb_tick_count #(
  parameter int unsigned DW = 32
) (
  input  logic          host_clk,
  input  logic          host_rst,
  input  logic          tmr_clk,
  input  logic          tmr_rst,
  output logic [DW-1:0] count
);
  logic tgl_q, s1, s2, s3;

  always_ff @(posedge tmr_clk) begin
    if (tmr_rst) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;
  end

  always_ff @(posedge host_clk) begin
    if (host_rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      s3    <= 1'b0;
      count <= '0;
    end else begin
      s1 <= tgl_q;
      s2 <= s1;
      s3 <= s2;
      if (s2 ^ s3) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/posted_reg_bank.sv
module posted_reg_bank import prb_pkg::*; #(
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 3,
  parameter int unsigned POST_BIT = 2
) (
  input  logic          host_clk,
  input  logic          host_rst,
  input  logic          tmr_clk,
  input  logic          tmr_rst,
  input  logic          host_valid,
  output logic          host_ready,
  input  logic          host_write,
  input  logic [AW-1:0] host_addr,
  input  logic [1:0]    host_size,
  input  logic [DW-1:0] host_wdata,
  output logic          host_rvalid,
  output logic [DW-1:0] host_rdata,
  output logic [DW-1:0] tmr_load,
  output logic [DW-1:0] tmr_cmp,
  output logic [DW-1:0] tmr_ctrl
);
  logic             accept_w, wr_acc, rd_acc;
  logic             post_en_q, stall_q;
  logic [NSLOT-1:0] stall_mask_q, pend_w, commit_w;
  logic [DW-1:0]    mirror_w [NSLOT];
  logic [DW-1:0]    tval_w   [NSLOT];
  logic [DW-1:0]    cnt_w, rd_mux;
  acc_e             kind_w;

  assign host_ready = ~stall_q;
  assign accept_w   = host_valid && host_ready;
  assign wr_acc     = accept_w && host_write;
  assign rd_acc     = accept_w && !host_write;
  assign kind_w     = acc_e'(host_size);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    prb_slot #(.DW(DW), .IS_CNT((g == 0) ? 1'b1 : 1'b0)) u_slot (
      .host_clk (host_clk),
      .host_rst (host_rst),
      .tmr_clk  (tmr_clk),
      .tmr_rst  (tmr_rst),
      .wr_en    (wr_acc && (host_addr == AW'(A_LOAD + g))),
      .wr_kind  (kind_w),
      .wr_data  (host_wdata),
      .commit   (commit_w[g]),
      .pending  (pend_w[g]),
      .mirror   (mirror_w[g]),
      .tmr_val  (tval_w[g])
    );
  end

  prb_tick_count #(.DW(DW)) u_count (
    .host_clk (host_clk),
    .host_rst (host_rst),
    .tmr_clk  (tmr_clk),
    .tmr_rst  (tmr_rst),
    .count    (cnt_w)
  );

  assign tmr_load = tval_w[0];
  assign tmr_cmp  = tval_w[1];
  assign tmr_ctrl = tval_w[2];

  always_ff @(posedge host_clk) begin
    if (host_rst) begin
      post_en_q    <= 1'b0;
      stall_q      <= 1'b0;
      stall_mask_q <= '0;
    end else begin
      if (wr_acc && host_addr == AW'(A_IFCTRL) &&
          (kind_w == SZ_FULL || kind_w == SZ_LO))
        post_en_q <= host_wdata[POST_BIT];
      if (stall_q) begin
        if ((pend_w & stall_mask_q) == '0) stall_q <= 1'b0;
      end else if (!post_en_q && (|commit_w)) begin
        stall_q      <= 1'b1;
        stall_mask_q <= commit_w;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (host_addr == AW'(A_IFCTRL))      rd_mux[POST_BIT]  = post_en_q;
    else if (host_addr == AW'(A_STAT))   rd_mux[NSLOT-1:0] = pend_w;
    else if (host_addr == AW'(A_COUNT))  rd_mux = cnt_w;
    else begin
      for (int i = 0; i < NSLOT; i++)
        if (host_addr == AW'(A_LOAD + i)) rd_mux = mirror_w[i];
    end
  end

  always_ff @(posedge host_clk) begin
    if (host_rst) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_acc;
      if (rd_acc) host_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/prb_checker.sv
module prb_checker #(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 3,
  parameter int unsigned NS    = 3
) (
  input logic          host_clk,
  input logic          host_rst,
  input logic          host_valid,
  input logic          host_ready,
  input logic          host_write,
  input logic [AW-1:0] host_addr,
  input logic [1:0]    host_size,
  input logic          host_rvalid,
  input logic          post_en_q,
  input logic [NS-1:0] pend_w,
  input logic [DW-1:0] cnt_w
);
  // R3: posting on means no request waits
  p_posted_ack_r3: assert property (@(posedge host_clk) disable iff (host_rst)
    post_en_q && host_valid |-> host_ready);

  // R4: reload update raises its status bit on the next cycle
  p_pend_set_r4: assert property (@(posedge host_clk) disable iff (host_rst)
    host_valid && host_ready && host_write && host_addr == AW'(2) && host_size != 2'b11
    |=> pend_w[0]);

  // R9: non-posted full write to match register stalls the port
  p_stall_r9: assert property (@(posedge host_clk) disable iff (host_rst)
    !post_en_q && host_valid && host_ready && host_write && host_addr == AW'(3) &&
    host_size == 2'b00 |=> !host_ready);

  // R10: counter steps by at most one
  p_count_step_r10: assert property (@(posedge host_clk) disable iff (host_rst)
    (cnt_w == $past(cnt_w)) || (cnt_w == $past(cnt_w) + 1'b1));

  // R11: read response follows acceptance
  p_read_resp_r11: assert property (@(posedge host_clk) disable iff (host_rst)
    host_valid && host_ready && !host_write |=> host_rvalid);
endmodule

bind posted_reg_bank prb_checker #(.DW(DW), .AW(AW), .NS(prb_pkg::NSLOT)) i_prb_checker (
  .host_clk    (host_clk),
  .host_rst    (host_rst),
  .host_valid  (host_valid),
  .host_ready  (host_ready),
  .host_write  (host_write),
  .host_addr   (host_addr),
  .host_size   (host_size),
  .host_rvalid (host_rvalid),
  .post_en_q   (post_en_q),
  .pend_w      (pend_w),
  .cnt_w       (cnt_w)
);

// File: tb/test_posted_reg_bank.sv
module test_posted_reg_bank;
  logic        hclk = 1'b0, tclk = 1'b0, hrst = 1'b1, trst = 1'b1;
  logic        valid = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic        ready, rvalid;
  logic [31:0] rdata, t_load, t_cmp, t_ctrl;

  int checks = 0, fails = 0;
  logic mon_on = 1'b0, saw_b = 1'b0, done = 1'b0;
  localparam logic [31:0] VAL_B = 32'hBBBB_0002;

  always #4  hclk = ~hclk;
  always #20 tclk = ~tclk;

  posted_reg_bank i_posted_reg_bank (
    .host_clk(hclk), .host_rst(hrst), .tmr_clk(tclk), .tmr_rst(trst),
    .host_valid(valid), .host_ready(ready), .host_write(wr), .host_addr(addr),
    .host_size(size), .host_wdata(wdata), .host_rvalid(rvalid), .host_rdata(rdata),
    .tmr_load(t_load), .tmr_cmp(t_cmp), .tmr_ctrl(t_ctrl)
  );

  always @(negedge hclk) if (mon_on && t_cmp == VAL_B) saw_b = 1'b1;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [1:0] sz, input logic [31:0] d, output int waits);
    waits = 0;
    @(negedge hclk);
    valid = 1'b1; wr = 1'b1; addr = a; size = sz; wdata = d;
    while (!ready) begin @(negedge hclk); waits++; end
    @(posedge hclk); #1;
    valid = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d, output logic rv);
    @(negedge hclk);
    valid = 1'b1; wr = 1'b0; addr = a;
    while (!ready) @(negedge hclk);
    @(posedge hclk); #1;
    valid = 1'b0;
    @(negedge hclk);
    d = rdata; rv = rvalid;
  endtask

  task automatic wait_idle(input logic [2:0] mask);
    logic [31:0] st; logic rv;
    for (int i = 0; i < 200; i++) begin
      bus_read(3'd1, st, rv);
      if ((st[2:0] & mask) == 3'b000) return;
    end
    chk(1'b0, "R4 idle timeout", st, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic rv;
    @(negedge hclk);
    chk(ready === 1'b1, "R1 ready", {31'b0, ready}, 32'h1);
    chk(t_load == 0 && t_cmp == 0 && t_ctrl == 0, "R1 timer outputs", t_load | t_cmp | t_ctrl, 32'h0);
    bus_read(3'd1, d, rv);
    chk(d == 0, "R1 status", d, 32'h0);
    chk(rv === 1'b1, "R11 rvalid after read", {31'b0, rv}, 32'h1);
    @(negedge hclk);
    chk(rvalid === 1'b0, "R11 rvalid single cycle", {31'b0, rvalid}, 32'h0);
    bus_read(3'd0, d, rv);
    chk(d == 0, "R1 posting off", d, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d; logic rv; int w;
    bus_write(3'd0, 2'b00, 32'hFFFF_FFFF, w);
    bus_read(3'd0, d, rv);
    chk(d == 32'h4, "R2 only bit 2 kept", d, 32'h4);
    bus_write(3'd0, 2'b10, 32'h0, w);
    bus_read(3'd0, d, rv);
    chk(d == 32'h4, "R2 high half ignored", d, 32'h4);
  endtask

  task automatic t_posted();
    logic [31:0] d; logic rv; int w;
    bus_write(3'd3, 2'b00, 32'h1234_5678, w);
    chk(w == 0, "R3 immediate accept", w, 32'h0);
    bus_read(3'd3, d, rv);
    chk(d == 32'h0, "R6 old value while pending", d, 32'h0);
    bus_read(3'd1, d, rv);
    chk(d == 32'h2, "R4 match bit set", d, 32'h2);
    wait_idle(3'b010);
    chk(t_cmp == 32'h1234_5678, "R4 applied after clear", t_cmp, 32'h1234_5678);
    bus_read(3'd3, d, rv);
    chk(d == 32'h1234_5678, "R4 readback new value", d, 32'h1234_5678);
  endtask

  task automatic t_last_wins();
    int w;
    saw_b = 1'b0; mon_on = 1'b1;
    bus_write(3'd3, 2'b00, 32'hAAAA_0001, w);
    bus_write(3'd3, 2'b00, VAL_B, w);
    bus_write(3'd3, 2'b00, 32'hCCCC_0003, w);
    chk(w == 0, "R3 accept while pending", w, 32'h0);
    wait_idle(3'b010);
    repeat (20) @(negedge hclk);
    mon_on = 1'b0;
    chk(t_cmp == 32'hCCCC_0003, "R5 newest value applied", t_cmp, 32'hCCCC_0003);
    chk(saw_b == 1'b0, "R5 replaced value never applied", {31'b0, saw_b}, 32'h0);
  endtask

  task automatic t_halves();
    logic [31:0] d; logic rv; int w;
    bus_write(3'd2, 2'b00, 32'h1111_2222, w);
    wait_idle(3'b001);
    bus_write(3'd2, 2'b01, 32'h0000_3333, w);
    bus_read(3'd1, d, rv);
    chk(d[0] == 1'b1, "R7 low half commits", d, 32'h1);
    wait_idle(3'b001);
    chk(t_load == 32'h1111_3333, "R7 merged reload", t_load, 32'h1111_3333);
    bus_write(3'd3, 2'b01, 32'h0000_5555, w);
    bus_read(3'd1, d, rv);
    chk(d == 32'h0, "R8 low half stages only", d, 32'h0);
    repeat (30) @(negedge hclk);
    chk(t_cmp == 32'hCCCC_0003, "R8 match unchanged", t_cmp, 32'hCCCC_0003);
    bus_write(3'd3, 2'b10, 32'h0000_6666, w);
    wait_idle(3'b010);
    chk(t_cmp == 32'h6666_5555, "R8 high half commits", t_cmp, 32'h6666_5555);
  endtask

  task automatic t_nonposted();
    logic [31:0] d; logic rv; int w, n;
    bus_write(3'd0, 2'b00, 32'h0, w);
    bus_write(3'd4, 2'b00, 32'h0000_00A5, w);
    @(negedge hclk);
    chk(ready == 1'b0, "R9 ready dropped", {31'b0, ready}, 32'h0);
    n = 0;
    while (!ready && n < 500) begin @(negedge hclk); n++; end
    chk(t_ctrl == 32'hA5, "R9 applied when ready returns", t_ctrl, 32'hA5);
    bus_read(3'd1, d, rv);
    chk(d == 32'h0, "R9 status clear", d, 32'h0);
  endtask

  task automatic t_counter();
    logic [31:0] c1, c2; logic rv;
    bus_read(3'd5, c1, rv);
    chk(c1 != 0, "R10 counter running", c1, 32'h1);
    repeat (100) @(negedge hclk);
    bus_read(3'd5, c2, rv);
    chk((c2 - c1) >= 19 && (c2 - c1) <= 22, "R10 tracks timer clock", c2 - c1, 32'd20);
  endtask

  initial begin
    repeat (10) @(negedge hclk);
    hrst = 1'b0; trst = 1'b0;
    t_reset();
    t_enable();
    t_posted();
    t_last_wins();
    t_halves();
    t_nonposted();
    t_counter();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge hclk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule